// File: doc/BRIEF.md
# Key-Gated Page-Latching Work RAM Controller

This block manages 5 KB of on-chip byte RAM placed in the CPU window from 0x6000 to 0x73FF. Three single-byte key registers, written by the CPU at 0x7EF7, 0x7EF8 and 0x7EF9, unlock the RAM. Each key opens a region that grows from the bottom of the window, and it opens it only while the key holds one exact value. Any access that no key opens is dropped. A read that no key opens returns zero, and so does a read of any other address.

Every access that a key opens also leaves a trace. The byte written or read is copied into the first byte of the 1 KB page that was accessed. The controller does this in two steps. It handles the target byte in the cycle that accepts the request. It writes the page byte in the following cycle, and it holds off new requests during that cycle. A read returns its data in the cycle after acceptance, which is the same cycle in which the page byte is written.

Top module: `keyram_ctrl`

## Requirements
- R1: After reset, all three keys are zero and the RAM is locked: `req_ready` is 1 and a read of 0x6000 returns 0x00.
- R2: Key register 0x7EF7 holding 0xCA opens offsets 0x000–0x7FF, so 0x67FF is readable and writable. With only this key set, a read of 0x6800 returns 0x00.
- R3: Key register 0x7EF8 holding 0x69 opens offsets 0x000–0xFFF. With only the first two keys set, a read of 0x7000 returns 0x00.
- R4: Key register 0x7EF9 holding 0x84 opens offsets 0x000–0x13FF.
- R5: A key holding any value other than its exact unlock value opens nothing. A write to a locked address does not change the stored byte, and a read of it returns 0x00.
- R6: A write that a key opens stores the byte at its address and also copies it to the byte at that address with offset bits 9:0 cleared.
- R7: A read that a key opens returns the stored byte and also copies that byte into the first byte of its 1 KB page.
- R8: A read outside 0x6000–0x73FF returns 0x00. This includes the key register addresses. `rsp_rdata` is 0x00 whenever `rsp_valid` is low.
- R9: `rsp_valid` is high exactly in the cycle after a read is accepted. `req_ready` is low for exactly one cycle after each accepted read and after each write that a key opens.
- R10: A write below 0x6000, or a write at 0x7400 or above that is not to a key register, changes no RAM byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data, 0x00 when locked or unmapped |

## Verification
The hardest case to reach is a page byte that holds a value left by a read rather than by a write. The page byte is overwritten on every write, so the stimulus has to place one value deep in a page, then write a second value elsewhere in the same page so that the page byte takes it. Reading the first location should then return the first value and push it into the page byte, and a read of the page byte itself shows whether that copy took place. Showing that a locked write is ignored takes a similar sequence: first store a known byte, then spoil the key, attempt the write, restore the key and read the byte back.

// File: rtl/keyram_pkg.sv
package keyram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAGE_WR = 2'd1,
        ST_READ    = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        ctrl_state_e state;
        logic        hit;
        logic [15:0] page;
        logic [7:0]  data;
    } ctrl_regs_t;
endpackage

// File: rtl/keyram_keys.sv
module keyram_keys #(
    parameter int              NUM_KEYS   = 3,
    parameter logic [15:0]     KEY_ADDR   = 16'h7EF7,
    parameter logic [NUM_KEYS*8-1:0]  KEY_VALUES = {8'h84, 8'h69, 8'hCA},
    parameter logic [NUM_KEYS*16-1:0] LIMITS     = {16'h1400, 16'h1000, 16'h0800}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        above_base,
    input  logic [15:0] offset,
    output logic        access_ok
);
    logic [7:0]          key_d [NUM_KEYS];
    logic [7:0]          key_q [NUM_KEYS];
    logic [NUM_KEYS-1:0] region_hit;

    always_comb begin
        for (int i = 0; i < NUM_KEYS; i++) begin
            key_d[i] = key_q[i];
            if (wr_en && wr_addr == KEY_ADDR + 16'(i))
                key_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_KEYS; i++)
            key_q[i] <= rst_n ? key_d[i] : 8'h00;
    end

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_region
        assign region_hit[g] = (offset < LIMITS[g*16 +: 16]) &&
                               (key_q[g] == KEY_VALUES[g*8 +: 8]);
    end

    assign access_ok = above_base && (|region_hit);
endmodule

// File: rtl/keyram_mem.sv
module keyram_mem #(
    parameter int DEPTH  = 5120,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[addr] <= wdata;
        rdata <= store[addr];
    end
endmodule

// File: rtl/keyram_ctrl.sv
module keyram_ctrl
    import keyram_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR  = 16'h6000,
    parameter int          RAM_BYTES  = 5120,
    parameter int          PAGE_BYTES = 1024,
    parameter logic [15:0] KEY_ADDR   = 16'h7EF7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [7:0]  rsp_rdata
);
    localparam int OFF_W = $clog2(RAM_BYTES);
    localparam int PG_W  = $clog2(PAGE_BYTES);

    ctrl_regs_t  r_d, r_q;
    logic [15:0] off_full;
    logic [15:0] page_of_req;
    logic        above_base;
    logic        ram_ok;
    logic        accept;
    logic        key_we;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    assign off_full    = req_addr - BASE_ADDR;
    assign above_base  = req_addr >= BASE_ADDR;
    assign page_of_req = {off_full[15:PG_W], PG_W'(0)};
    assign accept      = req_valid && (r_q.state == ST_IDLE);

    keyram_keys #(.KEY_ADDR(KEY_ADDR)) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (key_we),
        .wr_addr    (req_addr),
        .wr_data    (req_wdata),
        .above_base (above_base),
        .offset     (off_full),
        .access_ok  (ram_ok)
    );

    keyram_mem #(.DEPTH(RAM_BYTES), .DATA_W(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr[OFF_W-1:0]),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        r_d       = r_q;
        key_we    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = off_full;
        mem_wdata = req_wdata;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.page = page_of_req;
                    if (req_write) begin
                        key_we = 1'b1;
                        if (ram_ok) begin
                            mem_we      = 1'b1;
                            r_d.data    = req_wdata;
                            r_d.state   = ST_PAGE_WR;
                        end
                    end else begin
                        r_d.hit   = ram_ok;
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_PAGE_WR: begin
                mem_addr  = r_q.page;
                mem_wdata = r_q.data;
                mem_we    = 1'b1;
                r_d.state = ST_IDLE;
            end
            ST_READ: begin
                mem_addr  = r_q.page;
                mem_wdata = mem_rdata;
                mem_we    = r_q.hit;
                r_d.hit   = 1'b0;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.hit   <= 1'b0;
            r_q.page  <= 16'h0000;
            r_q.data  <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = (r_q.state == ST_READ);
    assign rsp_rdata = (rsp_valid && r_q.hit) ? mem_rdata : 8'h00;
endmodule

// File: rtl/keyram_ctrl_chk.sv
module keyram_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [7:0]  req_wdata,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [7:0]  rsp_rdata
);
    a_r9_read_responds_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rsp_valid && !req_ready));

    a_r9_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    a_r9_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write &&
         (req_addr < 16'h6000 || req_addr >= 16'h7400)) |=> (rsp_rdata == 8'h00));

    a_r8_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == 8'h00));

    a_r10_outside_write_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write &&
         (req_addr < 16'h6000 || req_addr >= 16'h7400)) |=> req_ready);
endmodule

bind keyram_ctrl keyram_ctrl_chk u_chk (.*);

// File: tb/keyram_ctrl_tb.sv
module keyram_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    keyram_ctrl u_dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, output logic stalled);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        stalled = !req_ready;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        logic s;
        do_write(a, d, s);
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic tim_ok);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        tim_ok = rsp_valid && !req_ready;
        @(negedge clk);
        tim_ok = tim_ok && req_ready && !rsp_valid;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic t;
        do_read(a, d, t);
        check(req, d, exp);
        check("R9 read timing", {7'd0, t}, 8'd1);
    endtask

    task automatic t_reset;
        check("R1 ready after reset", {7'd0, req_ready}, 8'd1);
        rd_check("R1 locked after reset", 16'h6000, 8'h00);
    endtask

    task automatic t_region0;
        logic s;
        wr(16'h7EF7, 8'hCA);
        do_write(16'h6005, 8'h3C, s);
        check("R9 stall after enabled write", {7'd0, s}, 8'd1);
        rd_check("R2 region0 data", 16'h6005, 8'h3C);
        rd_check("R6 page byte copy", 16'h6000, 8'h3C);
        wr(16'h67FF, 8'h5A);
        rd_check("R2 region0 top byte", 16'h67FF, 8'h5A);
        do_write(16'h6800, 8'h77, s);
        check("R2 no stall on locked write", {7'd0, s}, 8'd0);
        rd_check("R2 above region0 locked", 16'h6800, 8'h00);
    endtask

    task automatic t_region1;
        wr(16'h7EF8, 8'h69);
        wr(16'h6800, 8'h21);
        rd_check("R3 region1 data", 16'h6800, 8'h21);
        wr(16'h6FFF, 8'h44);
        rd_check("R3 region1 top byte", 16'h6FFF, 8'h44);
        rd_check("R3 above region1 locked", 16'h7000, 8'h00);
    endtask

    task automatic t_region2;
        wr(16'h7EF9, 8'h84);
        wr(16'h73FF, 8'h99);
        rd_check("R4 region2 top byte", 16'h73FF, 8'h99);
        rd_check("R8 above window", 16'h7400, 8'h00);
        rd_check("R8 below window", 16'h5FFF, 8'h00);
        rd_check("R8 key address read", 16'h7EF7, 8'h00);
    endtask

    task automatic t_read_copy;
        wr(16'h6C05, 8'hA1);
        wr(16'h6C10, 8'hB2);
        rd_check("R6 page byte follows last write", 16'h6C00, 8'hB2);
        rd_check("R7 read data", 16'h6C05, 8'hA1);
        rd_check("R7 read copied to page byte", 16'h6C00, 8'hA1);
    endtask

    task automatic t_wrong_key;
        wr(16'h7EF7, 8'h00);
        wr(16'h7EF8, 8'h68);
        wr(16'h7EF9, 8'h85);
        rd_check("R5 near-miss key locks", 16'h6800, 8'h00);
        wr(16'h6FFF, 8'hEE);
        wr(16'h7EF8, 8'h69);
        rd_check("R5 locked write ignored", 16'h6FFF, 8'h44);
    endtask

    task automatic t_outside;
        wr(16'h7EF9, 8'h84);
        wr(16'h5FFF, 8'h12);
        wr(16'h7400, 8'h34);
        wr(16'h7EF0, 8'h56);
        rd_check("R10 outside writes ignored", 16'h73FF, 8'h99);
        rd_check("R10 page byte unchanged", 16'h7000, 8'h99);
        rd_check("R10 low byte unchanged", 16'h6005, 8'h3C);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = 16'h0000; req_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region0();
        t_region1();
        t_region2();
        t_read_copy();
        t_wrong_key();
        t_outside();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule